// File: doc/BRIEF.md
# Mailbox Transmit-Cancel Controller

This block tracks transmit requests for 32 message mailboxes in a CAN-style controller, and it lets software withdraw a request that has not yet gone out. For each mailbox it keeps three bits: a pending-transmit flag, a cancel-request flag and an abort-acknowledge flag. Software raises pending flags through a dedicated 32-bit set path. It reads and writes the cancel-request and abort-acknowledge flags through four 16-bit register halves on a simple write-enable and read-data bus.

The transmit scheduler supplies two inputs. A one-hot vector shows which mailbox is on the bus, and a strobe marks the successful end of that frame. The block returns an eligible-to-send vector to the scheduler. A mailbox with a cancel request that has not started transmitting never shows up in that vector. The cancel is resolved in the cycle after it is written. If the mailbox is not on the bus in that cycle, the request is aborted and acknowledged. If the mailbox is already on the bus, the request cannot abort it and instead retires when the frame completes normally, with no acknowledge.

Top module: `tx_cancel_ctrl`

## Requirements
- R1: After reset every pending, cancel and acknowledge bit is 0. Reads of all four register halves return 0.
- R2: Register address 0 holds the cancel bits of mailboxes 0..15 and address 1 holds those of mailboxes 16..31. Address 2 holds the acknowledge bits of mailboxes 0..15 and address 3 holds those of mailboxes 16..31. In each half, bit k maps to mailbox k (low half) or mailbox 16+k (high half). Read data shows the current state of the addressed half.
- R3: Writing 1 to the cancel bit of mailbox n sets that bit at the write edge if mailbox n is a transmit mailbox (tx_mb_mask_i bit n = 1) and its pending bit is 1.
- R4: Writing 0 to a cancel bit changes nothing. A 1 written to the cancel bit of a mailbox whose mask bit is 0 is ignored.
- R5: A 1 written to the cancel bit of a mailbox whose pending bit is 0 leaves both its cancel bit and its acknowledge bit at 0.
- R6: At the edge after the cancel bit is set, if the mailbox's busy bit is 0, the pending and cancel bits clear and the acknowledge bit sets.
- R7: If the mailbox's busy bit is 1 while its cancel bit is set, the cancel bit holds. When tx_done_i is then sampled high, the pending and cancel bits clear and the acknowledge bit stays 0.
- R8: tx_done_i clears the pending bit of the mailbox whose busy bit is 1. With no busy bit set, tx_done_i has no effect.
- R9: Writing 1 to an acknowledge bit clears it and writing 0 leaves it unchanged. If an abort sets the bit in the same cycle, the set wins.
- R10: A 1 on pend_set_i bit n sets pending bit n. If a clear occurs in the same cycle, the set wins.
- R11: eligible_o equals pending AND NOT (cancel AND NOT busy).
- R12: A mailbox whose busy bit rises in the cycle the cancel is resolved counts as already started. Its cancel bit holds, and no acknowledge is given.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| reg_we_i | input | 1 | Register write enable |
| reg_addr_i | input | 2 | Register half select (0/1 cancel, 2/3 acknowledge) |
| reg_wdata_i | input | 16 | Register write data |
| reg_rdata_o | output | 16 | Read data of the addressed half |
| pend_set_i | input | 32 | Write-1 set of pending bits |
| tx_mb_mask_i | input | 32 | 1 marks a transmit mailbox |
| busy_onehot_i | input | 32 | Mailbox currently on the bus (one-hot or zero) |
| tx_done_i | input | 1 | Successful end of the current frame |
| pend_o | output | 32 | Pending-transmit bits |
| eligible_o | output | 32 | Mailboxes the scheduler may select |

## Verification
Some properties are checked by assertions on every cycle. A cancel bit is never set without its pending bit. An idle cancel always turns into an acknowledge with pending and cancel cleared. A cancel on a busy mailbox holds until completion. An acknowledge never rises without an idle cancel the cycle before. Completion clears the busy mailbox's pending bit. Other behaviour needs the bench's scenarios. These are the register half layout, ignored writes to non-transmit or idle mailboxes, the race of a frame start against the resolve cycle, and the priority of sets over clears.

// File: rtl/tcc_pkg.sv
package tcc_pkg;
  typedef enum logic [1:0] {
    REG_CAN_LO = 2'd0,
    REG_CAN_HI = 2'd1,
    REG_ACK_LO = 2'd2,
    REG_ACK_HI = 2'd3
  } reg_addr_e;
endpackage

// File: rtl/tcc_reg_if.sv
module tcc_reg_if
  import tcc_pkg::*;
#(
  parameter int HALF_W = 16
) (
  input  logic                  we_i,
  input  logic [1:0]            addr_i,
  input  logic [HALF_W-1:0]     wdata_i,
  input  logic [2*HALF_W-1:0]   cancel_i,
  input  logic [2*HALF_W-1:0]   ack_i,
  output logic [2*HALF_W-1:0]   cancel_wr_o,
  output logic [2*HALF_W-1:0]   ack_clr_o,
  output logic [HALF_W-1:0]     rdata_o
);
  localparam int NUM_MB = 2 * HALF_W;

  reg_addr_e addr;
  assign addr = reg_addr_e'(addr_i);

  always_comb begin
    cancel_wr_o = '0;
    ack_clr_o   = '0;
    if (we_i) begin
      unique case (addr)
        REG_CAN_LO: cancel_wr_o[HALF_W-1:0]      = wdata_i;
        REG_CAN_HI: cancel_wr_o[NUM_MB-1:HALF_W] = wdata_i;
        REG_ACK_LO: ack_clr_o[HALF_W-1:0]        = wdata_i;
        REG_ACK_HI: ack_clr_o[NUM_MB-1:HALF_W]   = wdata_i;
        default: ;
      endcase
    end
  end

  always_comb begin
    unique case (addr)
      REG_CAN_LO: rdata_o = cancel_i[HALF_W-1:0];
      REG_CAN_HI: rdata_o = cancel_i[NUM_MB-1:HALF_W];
      REG_ACK_LO: rdata_o = ack_i[HALF_W-1:0];
      REG_ACK_HI: rdata_o = ack_i[NUM_MB-1:HALF_W];
      default:    rdata_o = '0;
    endcase
  end
endmodule

// File: rtl/tcc_mb_slice.sv
module tcc_mb_slice (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic pend_set_i,
  input  logic cancel_wr_i,
  input  logic ack_clr_i,
  input  logic is_tx_i,
  input  logic busy_i,
  input  logic done_i,
  output logic pend_o,
  output logic cancel_o,
  output logic ack_o,
  output logic elig_o
);
  logic pend_q, cancel_q, ack_q;
  logic accept, abort, finish, retire;

  // request only latches on a waiting transmit mailbox
  assign accept = cancel_wr_i & is_tx_i & pend_q;
  // resolved one cycle after the write; busy now means the frame already started
  assign abort  = cancel_q & ~busy_i;
  assign finish = busy_i & done_i;
  assign retire = abort | finish;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pend_q   <= 1'b0;
      cancel_q <= 1'b0;
      ack_q    <= 1'b0;
    end else begin
      pend_q   <= pend_set_i | (pend_q & ~retire);
      cancel_q <= retire ? 1'b0 : (cancel_q | accept);
      ack_q    <= abort | (ack_q & ~ack_clr_i);
    end
  end

  assign pend_o   = pend_q;
  assign cancel_o = cancel_q;
  assign ack_o    = ack_q;
  assign elig_o   = pend_q & ~(cancel_q & ~busy_i);
endmodule

// File: rtl/tx_cancel_ctrl.sv
module tx_cancel_ctrl #(
  parameter int HALF_W = 16
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                reg_we_i,
  input  logic [1:0]          reg_addr_i,
  input  logic [HALF_W-1:0]   reg_wdata_i,
  output logic [HALF_W-1:0]   reg_rdata_o,
  input  logic [2*HALF_W-1:0] pend_set_i,
  input  logic [2*HALF_W-1:0] tx_mb_mask_i,
  input  logic [2*HALF_W-1:0] busy_onehot_i,
  input  logic                tx_done_i,
  output logic [2*HALF_W-1:0] pend_o,
  output logic [2*HALF_W-1:0] eligible_o
);
  localparam int NUM_MB = 2 * HALF_W;

  logic [NUM_MB-1:0] cancel_wr, ack_clr;
  logic [NUM_MB-1:0] cancel_vec, ack_vec;

  tcc_reg_if #(.HALF_W(HALF_W)) u_reg_if (
    .we_i        (reg_we_i),
    .addr_i      (reg_addr_i),
    .wdata_i     (reg_wdata_i),
    .cancel_i    (cancel_vec),
    .ack_i       (ack_vec),
    .cancel_wr_o (cancel_wr),
    .ack_clr_o   (ack_clr),
    .rdata_o     (reg_rdata_o)
  );

  for (genvar i = 0; i < NUM_MB; i++) begin : g_mb
    tcc_mb_slice u_slice (
      .clk_i       (clk_i),
      .rst_ni      (rst_ni),
      .pend_set_i  (pend_set_i[i]),
      .cancel_wr_i (cancel_wr[i]),
      .ack_clr_i   (ack_clr[i]),
      .is_tx_i     (tx_mb_mask_i[i]),
      .busy_i      (busy_onehot_i[i]),
      .done_i      (tx_done_i),
      .pend_o      (pend_o[i]),
      .cancel_o    (cancel_vec[i]),
      .ack_o       (ack_vec[i]),
      .elig_o      (eligible_o[i])
    );
  end
endmodule

// File: rtl/tcc_checker.sv
module tcc_checker #(
  parameter int HALF_W = 16
) (
  input logic                clk_i,
  input logic                rst_ni,
  input logic [2*HALF_W-1:0] pend_set_i,
  input logic [2*HALF_W-1:0] tx_mb_mask_i,
  input logic [2*HALF_W-1:0] busy_onehot_i,
  input logic                tx_done_i,
  input logic [2*HALF_W-1:0] pend_o,
  input logic [2*HALF_W-1:0] eligible_o,
  input logic [2*HALF_W-1:0] cancel_vec,
  input logic [2*HALF_W-1:0] ack_vec
);
  localparam int NUM_MB = 2 * HALF_W;
  logic [NUM_MB-1:0] done_vec;
  assign done_vec = {NUM_MB{tx_done_i}};

  assert_cancel_needs_pend_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cancel_vec & ~pend_o) == '0);

  assert_non_tx_ignored_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    1'b1 |=> (cancel_vec & ~$past(cancel_vec) & ~$past(tx_mb_mask_i)) == '0);

  assert_abort_acks_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    1'b1 |=> ((ack_vec & $past(cancel_vec & ~busy_onehot_i)) == $past(cancel_vec & ~busy_onehot_i))
          && ((cancel_vec & $past(cancel_vec & ~busy_onehot_i)) == '0)
          && ((pend_o & $past(cancel_vec & ~busy_onehot_i) & ~$past(pend_set_i)) == '0));

  assert_started_holds_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    1'b1 |=> (cancel_vec & $past(cancel_vec & busy_onehot_i & ~done_vec))
             == $past(cancel_vec & busy_onehot_i & ~done_vec));

  assert_ack_only_from_abort_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    1'b1 |=> (ack_vec & ~$past(ack_vec) & ~$past(cancel_vec & ~busy_onehot_i)) == '0);

  assert_done_clears_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    1'b1 |=> (pend_o & $past(busy_onehot_i & done_vec) & ~$past(pend_set_i)) == '0);

  assert_elig_subset_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (eligible_o & ~pend_o) == '0);
endmodule

bind tx_cancel_ctrl tcc_checker #(.HALF_W(HALF_W)) u_chk (
  .clk_i         (clk_i),
  .rst_ni        (rst_ni),
  .pend_set_i    (pend_set_i),
  .tx_mb_mask_i  (tx_mb_mask_i),
  .busy_onehot_i (busy_onehot_i),
  .tx_done_i     (tx_done_i),
  .pend_o        (pend_o),
  .eligible_o    (eligible_o),
  .cancel_vec    (cancel_vec),
  .ack_vec       (ack_vec)
);

// File: tb/tx_cancel_ctrl_tb.sv
`timescale 1ns/1ps
module tx_cancel_ctrl_tb;
  localparam logic [31:0] MASK = 32'hF0FF_7FDF;

  logic        clk = 1'b0;
  logic        rst_ni = 1'b0;
  logic        reg_we_i = 1'b0;
  logic [1:0]  reg_addr_i = '0;
  logic [15:0] reg_wdata_i = '0;
  logic [15:0] reg_rdata_o;
  logic [31:0] pend_set_i = '0;
  logic [31:0] tx_mb_mask_i = MASK;
  logic [31:0] busy_onehot_i = '0;
  logic        tx_done_i = 1'b0;
  logic [31:0] pend_o, eligible_o;

  int total = 0;
  int bad = 0;
  logic [31:0] m_pend = '0, m_can = '0, m_ack = '0;

  always #5 clk = ~clk;

  tx_cancel_ctrl u_dut (
    .clk_i(clk), .rst_ni(rst_ni), .reg_we_i(reg_we_i), .reg_addr_i(reg_addr_i),
    .reg_wdata_i(reg_wdata_i), .reg_rdata_o(reg_rdata_o), .pend_set_i(pend_set_i),
    .tx_mb_mask_i(tx_mb_mask_i), .busy_onehot_i(busy_onehot_i), .tx_done_i(tx_done_i),
    .pend_o(pend_o), .eligible_o(eligible_o)
  );

  task automatic chk(string tag, logic [31:0] got, logic [31:0] exp);
    total++;
    if (got !== exp) begin
      bad++;
      $display("FAIL %s got=%h exp=%h", tag, got, exp);
    end
  endtask

  function automatic logic [15:0] mdl_rd(logic [1:0] a);
    case (a)
      2'd0:    return m_can[15:0];
      2'd1:    return m_can[31:16];
      2'd2:    return m_ack[15:0];
      default: return m_ack[31:16];
    endcase
  endfunction

  task automatic step(string tag, logic we, logic [1:0] a, logic [15:0] wd,
                      logic [31:0] st, logic [31:0] bz, logic dn);
    logic [31:0] wb, acc, clr, ab, fin;
    @(negedge clk);
    reg_we_i = we; reg_addr_i = a; reg_wdata_i = wd;
    pend_set_i = st; busy_onehot_i = bz; tx_done_i = dn;
    @(posedge clk); #1;
    wb  = a[0] ? {wd, 16'h0} : {16'h0, wd};
    acc = (we && !a[1]) ? (wb & MASK & m_pend) : '0;
    clr = (we && a[1]) ? wb : '0;
    ab  = m_can & ~bz;
    fin = dn ? bz : '0;
    m_can  = (m_can | acc) & ~(ab | fin);
    m_pend = st | (m_pend & ~(ab | fin));
    m_ack  = ab | (m_ack & ~clr);
    chk({tag, " pend"}, pend_o, m_pend);
    chk({tag, " R11 elig"}, eligible_o, m_pend & ~(m_can & ~bz));
    chk({tag, " R2 rdata"}, {16'h0, reg_rdata_o}, {16'h0, mdl_rd(a)});
  endtask

  initial begin
    #1_000_000;
    bad++;
    $display("FAIL watchdog R1 got=hung exp=done");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    logic [31:0] bz;
    void'($urandom(32'd1234));
    repeat (3) @(negedge clk);
    #1 chk("R1 reset pend", pend_o, 32'h0);
    rst_ni = 1'b1;
    for (int a = 0; a < 4; a++) begin
      step("R1", 1'b0, 2'(a), 16'h0, 32'h0, 32'h0, 1'b0);
      chk("R1 rdata zero", {16'h0, reg_rdata_o}, 32'h0);
    end
    // pend on 1,3,5,9,20
    step("R10 set", 1'b0, 2'd0, 16'h0, 32'h0010_022A, 32'h0, 1'b0);
    chk("R10 pend set", pend_o, 32'h0010_022A);
    // cancel bits 3 (ok), 5 (non-tx), 7 (not pending)
    step("R3", 1'b1, 2'd0, 16'h00A8, 32'h0, 32'h0, 1'b0);
    chk("R3 R4 R5 cancel lo", {16'h0, reg_rdata_o}, 32'h0000_0008);
    chk("R11 canceled idle not eligible", {31'h0, eligible_o[3]}, 32'h0);
    step("R6", 1'b0, 2'd2, 16'h0, 32'h0, 32'h0, 1'b0);
    chk("R6 ack lo", {16'h0, reg_rdata_o}, 32'h0000_0008);
    chk("R6 pend cleared", {31'h0, pend_o[3]}, 32'h0);
    step("R9", 1'b1, 2'd2, 16'h0008, 32'h0, 32'h0, 1'b0);
    chk("R9 ack w1c", {16'h0, reg_rdata_o}, 32'h0);
    // mailbox 20 on the bus, then cancel
    step("R7", 1'b0, 2'd1, 16'h0, 32'h0, 32'h0010_0000, 1'b0);
    step("R7", 1'b1, 2'd1, 16'h0010, 32'h0, 32'h0010_0000, 1'b0);
    step("R7", 1'b0, 2'd1, 16'h0, 32'h0, 32'h0010_0000, 1'b0);
    step("R4", 1'b1, 2'd1, 16'h0000, 32'h0, 32'h0010_0000, 1'b0);
    chk("R4 R7 cancel held", {16'h0, reg_rdata_o}, 32'h0000_0010);
    chk("R11 busy stays eligible", {31'h0, eligible_o[20]}, 32'h1);
    step("R7", 1'b0, 2'd3, 16'h0, 32'h0, 32'h0010_0000, 1'b1);
    chk("R7 no ack on completion", {16'h0, reg_rdata_o}, 32'h0);
    chk("R7 pend cleared", {31'h0, pend_o[20]}, 32'h0);
    step("R7", 1'b0, 2'd1, 16'h0, 32'h0, 32'h0, 1'b0);
    chk("R7 cancel retired", {16'h0, reg_rdata_o}, 32'h0);
    // race: mailbox 9 starts in resolve cycle
    step("R12", 1'b1, 2'd0, 16'h0200, 32'h0, 32'h0, 1'b0);
    step("R12", 1'b0, 2'd0, 16'h0, 32'h0, 32'h0000_0200, 1'b0);
    chk("R12 race counts started", {16'h0, reg_rdata_o}, 32'h0000_0200);
    step("R12", 1'b0, 2'd2, 16'h0, 32'h0, 32'h0000_0200, 1'b1);
    chk("R12 no ack", {16'h0, reg_rdata_o}, 32'h0);
    // ack set wins over same-cycle clear on mailbox 1
    step("R9", 1'b1, 2'd0, 16'h0002, 32'h0, 32'h0, 1'b0);
    step("R9", 1'b1, 2'd2, 16'h0002, 32'h0, 32'h0, 1'b0);
    chk("R9 set wins", {16'h0, reg_rdata_o}, 32'h0000_0002);
    // mailbox 5 still pending: set vs done
    step("R10", 1'b0, 2'd0, 16'h0, 32'h0000_0020, 32'h0000_0020, 1'b1);
    chk("R10 set wins", {31'h0, pend_o[5]}, 32'h1);
    step("R8", 1'b0, 2'd0, 16'h0, 32'h0, 32'h0000_0020, 1'b1);
    chk("R8 done clears", {31'h0, pend_o[5]}, 32'h0);
    step("R8", 1'b0, 2'd0, 16'h0, 32'h0000_0004, 32'h0, 1'b0);
    step("R8", 1'b0, 2'd0, 16'h0, 32'h0, 32'h0, 1'b1);
    chk("R8 done without busy", {31'h0, pend_o[2]}, 32'h1);
    // constrained random
    bz = '0;
    for (int i = 0; i < 4000; i++) begin
      logic dn, we;
      if ($urandom_range(7) == 0)
        bz = ($urandom_range(2) == 0) ? 32'h0 : (32'h1 << $urandom_range(31));
      dn = (bz != 0) && ($urandom_range(5) == 0);
      we = ($urandom_range(2) == 0);
      step("R3 R6 R7 rnd", we, 2'($urandom_range(3)),
           16'($urandom & $urandom), $urandom & $urandom & $urandom, bz, dn);
      if (dn) bz = '0;
    end
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule